// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an external host reach a bank of 64 register addresses, each 24 bits wide, over a four-wire serial link. The chip select is active high. Every transfer is a fixed 32-clock frame, made of a direction bit, a 6-bit address sent most significant bit first, one spare bit that gives decode time, and 24 data bits sent most significant bit first. A direction bit of 1 asks for a write. A direction bit of 0 asks for a read. In both cases the slave returns the current contents of the addressed register on MISO, in the data-bit slots. A write takes effect on the falling edge of the 32nd serial clock. A frame whose select drops earlier leaves every register untouched.

The serial pins are sampled with the block's own system clock. The clock edges are recovered from the synchronized serial clock. The address space holds four kinds of register, in this order: a group of read/write control registers (these drive a parallel output bus for the rest of the chip), a group of read-only status registers (these mirror input buses), a group of interrupt-style flags that a write of 1 clears, and a group of flags that a completed read clears. Higher addresses are unused and read as zero. Bits left clear in a mask parameter are unused in every register. They always store and return zero.

Top module: `spi_reg_slave`

## Requirements
- R1: A frame with direction bit 1 stores its 24 data bits into the addressed read/write register. The bus carries 1 bit of direction, then address bits 5 down to 0, then one ignored bit, then data bits 23 down to 0. The store happens once, after the 32nd falling clock edge.
- R2: A frame with direction bit 0 changes no read/write register, whatever data bits it carries.
- R3: In every frame, MISO is 0 before the first data-bit rising edge. In data slot k (k = 0..23), MISO presents bit 23-k of the addressed register's current value. It is valid at the rising edge of that slot.
- R4: If chip select goes low at any point before the 32nd falling edge, no register is modified. This includes the interval between the 32nd rising edge and the 32nd falling edge.
- R5: While chip select is low, the MISO output enable is 0 and MISO is 0.
- R6: Bits that are 0 in USED_MASK (default 24'hFFF0FF) always store and read back as 0. Unused addresses (14..63 by default) accept writes without effect and read as 0.
- R7: Read-only addresses (8 and 9 by default) return their status input, masked. Writes to them have no effect.
- R8: Interrupt flag addresses (10 and 11 by default) are set by event input pulses. A write clears exactly the bits written as 1 and leaves the rest.
- R9: Read-clear flag addresses (12 and 13 by default) are set by event pulses. A completed read frame clears only the bits it returned. An event that arrives after the value was captured survives the read.
- R10: Serial clocks after the 32nd, with chip select still high, are ignored. They cause no second store and MISO stays 0. A new frame needs chip select to go low and then high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs | input | 1 | Chip select, active high |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | MISO output enable for the pad, high while selected |
| ro_status | input | NRO*24 | Status values for the read-only registers |
| evt_w1c | input | NW1C*24 | Set pulses for the write-one-to-clear flags |
| evt_cor | input | NCOR*24 | Set pulses for the clear-on-read flags |
| rw_out | output | NRW*24 | Contents of the read/write registers |

## Verification
The bench aborts frames at two points. One is partway through the data. The other is after the 32nd rising edge but before its falling edge. A design that commits early would alter the register in one of these cases. The bench injects a read-clear event mid-frame, after the value has been captured. A design that clears the whole register on read would lose that event. The bench also drives a read frame that carries all-ones data, a write of mixed ones and zeros to an interrupt flag register, writes to the read-only and unused addresses, and extra clocks after a completed write. A design that got any of these wrong would store the read frame's data, clear the wrong flags, let a write reach a register it should not touch, or shift and store a second time. MISO is checked at every host sampling point, so an off-by-one slot in the output shift would show as a bit mismatch.

// File: rtl/spi_regs_pkg.sv
`timescale 1ns/1ps
// Shared constants, types and the address decoder for the SPI register slave.
// Assumes the four register groups are packed from address 0 upwards.
package spi_regs_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 24;

    typedef enum logic [2:0] {
        ACC_RW,
        ACC_RO,
        ACC_W1C,
        ACC_COR,
        ACC_NONE
    } acc_e;

    typedef struct packed {
        acc_e              kind;
        logic [ADDR_W-1:0] idx;
    } slot_t;

    // Map a frame address to its register kind and index inside that group.
    function automatic slot_t decode_slot(input logic [ADDR_W-1:0] a,
                                          input int nrw, input int nro,
                                          input int nw1c, input int ncor);
        slot_t s;
        int    ai;
        ai     = int'(a);
        s.kind = ACC_NONE;
        s.idx  = '0;
        if (ai < nrw) begin
            s.kind = ACC_RW;
            s.idx  = ADDR_W'(ai);
        end else if (ai < nrw + nro) begin
            s.kind = ACC_RO;
            s.idx  = ADDR_W'(ai - nrw);
        end else if (ai < nrw + nro + nw1c) begin
            s.kind = ACC_W1C;
            s.idx  = ADDR_W'(ai - nrw - nro);
        end else if (ai < nrw + nro + nw1c + ncor) begin
            s.kind = ACC_COR;
            s.idx  = ADDR_W'(ai - nrw - nro - nw1c);
        end
        return s;
    endfunction

endpackage

// File: rtl/spi_frame_engine.sv
`timescale 1ns/1ps
// Serial frame engine: recovers the SPI clock edges on the system clock,
// collects direction, address and data, and shifts the read value out on MISO.
// It issues one commit strobe after the 32nd falling edge.
// Assumes the system clock is at least 8x faster than the serial clock, and
// that the serial clock is low when chip select rises.
module spi_frame_engine
    import spi_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_stb,
    output logic              cor_stb,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cor_mask,
    output logic              miso_q,
    output logic              miso_oe
);
    localparam int FRAME_BITS = ADDR_W + DATA_W + 2;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_ADDR_LAST = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] CNT_DEAD      = CNT_W'(ADDR_W + 1);
    localparam logic [CNT_W-1:0] CNT_DFIRST    = CNT_W'(ADDR_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL      = CNT_W'(FRAME_BITS);

    logic [1:0]        cs_s;
    logic [1:0]        mosi_s;
    logic [2:0]        sck_s;
    logic [CNT_W-1:0]  cnt;
    logic              done;
    logic              dir_q;
    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] snap_q;
    logic              cs_on;
    logic              sck_rise;
    logic              sck_fall;

    // Two-stage synchronizers for the serial pins, plus one delay stage for clock edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_s   <= '0;
            mosi_s <= '0;
            sck_s  <= '0;
        end else begin
            cs_s   <= {cs_s[0], spi_cs};
            mosi_s <= {mosi_s[0], spi_mosi};
            sck_s  <= {sck_s[1:0], spi_sck};
        end
    end

    assign cs_on    = cs_s[1];
    assign sck_rise = sck_s[1] & ~sck_s[2];
    assign sck_fall = ~sck_s[1] & sck_s[2];

    // Frame sequencing: bit count, receive shift, address latch, transmit shift and commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            done    <= 1'b0;
            dir_q   <= 1'b0;
            addr    <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            snap_q  <= '0;
            miso_q  <= 1'b0;
            wr_stb  <= 1'b0;
            cor_stb <= 1'b0;
        end else begin
            wr_stb  <= 1'b0;
            cor_stb <= 1'b0;
            if (!cs_on) begin
                cnt    <= '0;
                done   <= 1'b0;
                dir_q  <= 1'b0;
                addr   <= '0;
                rx_q   <= '0;
                tx_q   <= '0;
                snap_q <= '0;
                miso_q <= 1'b0;
            end else begin
                if (sck_rise && cnt != CNT_FULL) begin
                    cnt  <= cnt + 1'b1;
                    rx_q <= {rx_q[DATA_W-2:0], mosi_s[1]};
                    if (cnt == CNT_ADDR_LAST) begin
                        addr  <= {rx_q[ADDR_W-2:0], mosi_s[1]};
                        dir_q <= rx_q[ADDR_W-1];
                    end
                    if (cnt == CNT_DEAD) begin
                        tx_q   <= rd_data;
                        snap_q <= rd_data;
                    end
                end
                if (sck_fall) begin
                    if (cnt >= CNT_DFIRST && cnt < CNT_FULL) begin
                        miso_q <= tx_q[DATA_W-1];
                        tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
                    end else begin
                        miso_q <= 1'b0;
                    end
                    if (cnt == CNT_FULL && !done) begin
                        done    <= 1'b1;
                        wr_stb  <= dir_q;
                        cor_stb <= ~dir_q;
                    end
                end
            end
        end
    end

    assign wr_data  = rx_q;
    assign cor_mask = snap_q;
    assign miso_oe  = cs_on;

endmodule

// File: rtl/spi_reg_bank.sv
`timescale 1ns/1ps
// Register bank: read/write, read-only, write-one-to-clear and clear-on-read
// groups, with a combinational read port. Unused bits are forced to zero.
// Assumes each group has at least one register and all groups fit in 64 addresses.
module spi_reg_bank
    import spi_regs_pkg::*;
#(
    parameter int                NRW       = 8,
    parameter int                NRO       = 2,
    parameter int                NW1C      = 2,
    parameter int                NCOR      = 2,
    parameter logic [DATA_W-1:0] USED_MASK = 24'hFFF0FF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   wr_stb,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   cor_stb,
    input  logic [DATA_W-1:0]      cor_mask,
    input  logic [NRO*DATA_W-1:0]  ro_status,
    input  logic [NW1C*DATA_W-1:0] evt_w1c,
    input  logic [NCOR*DATA_W-1:0] evt_cor,
    output logic [DATA_W-1:0]      rd_data,
    output logic [NRW*DATA_W-1:0]  rw_out
);
    logic [DATA_W-1:0] rw_q  [NRW];
    logic [DATA_W-1:0] w1c_q [NW1C];
    logic [DATA_W-1:0] cor_q [NCOR];
    slot_t             slot;

    assign slot = decode_slot(addr, NRW, NRO, NW1C, NCOR);

    // Register updates: host writes, flag clears and event sets (set wins over clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NRW; i++)  rw_q[i]  <= '0;
            for (int i = 0; i < NW1C; i++) w1c_q[i] <= '0;
            for (int i = 0; i < NCOR; i++) cor_q[i] <= '0;
        end else begin
            for (int i = 0; i < NRW; i++) begin
                if (wr_stb && slot.kind == ACC_RW && slot.idx == ADDR_W'(i))
                    rw_q[i] <= wr_data & USED_MASK;
            end
            for (int i = 0; i < NW1C; i++) begin
                w1c_q[i] <= ((w1c_q[i] &
                             ~((wr_stb && slot.kind == ACC_W1C && slot.idx == ADDR_W'(i)) ? wr_data : '0))
                             | evt_w1c[i*DATA_W +: DATA_W]) & USED_MASK;
            end
            for (int i = 0; i < NCOR; i++) begin
                cor_q[i] <= ((cor_q[i] &
                             ~((cor_stb && slot.kind == ACC_COR && slot.idx == ADDR_W'(i)) ? cor_mask : '0))
                             | evt_cor[i*DATA_W +: DATA_W]) & USED_MASK;
            end
        end
    end

    // Read multiplexer for the addressed register, masked to the used bits.
    always_comb begin
        rd_data = '0;
        case (slot.kind)
            ACC_RW:  for (int i = 0; i < NRW; i++)
                         if (slot.idx == ADDR_W'(i)) rd_data = rw_q[i];
            ACC_RO:  for (int i = 0; i < NRO; i++)
                         if (slot.idx == ADDR_W'(i)) rd_data = ro_status[i*DATA_W +: DATA_W];
            ACC_W1C: for (int i = 0; i < NW1C; i++)
                         if (slot.idx == ADDR_W'(i)) rd_data = w1c_q[i];
            ACC_COR: for (int i = 0; i < NCOR; i++)
                         if (slot.idx == ADDR_W'(i)) rd_data = cor_q[i];
            default: rd_data = '0;
        endcase
        rd_data = rd_data & USED_MASK;
    end

    // Parallel view of the read/write registers for the rest of the chip.
    for (genvar g = 0; g < NRW; g++) begin : g_rw_out
        assign rw_out[g*DATA_W +: DATA_W] = rw_q[g];
    end

endmodule

// File: rtl/spi_reg_slave.sv
`timescale 1ns/1ps
// Top of the SPI register slave: joins the frame engine to the register bank.
// MISO is driven with an output enable; the pad performs the tri-state.
// Assumes an active-high chip select and 32-bit frames.
module spi_reg_slave
    import spi_regs_pkg::*;
#(
    parameter int                NRW       = 8,
    parameter int                NRO       = 2,
    parameter int                NW1C      = 2,
    parameter int                NCOR      = 2,
    parameter logic [DATA_W-1:0] USED_MASK = 24'hFFF0FF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   spi_cs,
    input  logic                   spi_sck,
    input  logic                   spi_mosi,
    output logic                   spi_miso,
    output logic                   spi_miso_oe,
    input  logic [NRO*DATA_W-1:0]  ro_status,
    input  logic [NW1C*DATA_W-1:0] evt_w1c,
    input  logic [NCOR*DATA_W-1:0] evt_cor,
    output logic [NRW*DATA_W-1:0]  rw_out
);
    logic [ADDR_W-1:0] addr;
    logic              wr_stb;
    logic              cor_stb;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] cor_mask;
    logic [DATA_W-1:0] rd_data;
    logic              miso_q;

    spi_frame_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_cs   (spi_cs),
        .spi_sck  (spi_sck),
        .spi_mosi (spi_mosi),
        .rd_data  (rd_data),
        .addr     (addr),
        .wr_stb   (wr_stb),
        .cor_stb  (cor_stb),
        .wr_data  (wr_data),
        .cor_mask (cor_mask),
        .miso_q   (miso_q),
        .miso_oe  (spi_miso_oe)
    );

    spi_reg_bank #(
        .NRW       (NRW),
        .NRO       (NRO),
        .NW1C      (NW1C),
        .NCOR      (NCOR),
        .USED_MASK (USED_MASK)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .cor_stb   (cor_stb),
        .cor_mask  (cor_mask),
        .ro_status (ro_status),
        .evt_w1c   (evt_w1c),
        .evt_cor   (evt_cor),
        .rd_data   (rd_data),
        .rw_out    (rw_out)
    );

    // MISO data is gated by the enable so the line is quiet when deselected.
    assign spi_miso = miso_q & spi_miso_oe;

endmodule

// File: rtl/spi_reg_slave_chk.sv
`timescale 1ns/1ps
// Property checker for the SPI register slave, bound into the top module.
module spi_reg_slave_chk
    import spi_regs_pkg::*;
#(
    parameter int                NRW       = 8,
    parameter logic [DATA_W-1:0] USED_MASK = 24'hFFF0FF
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  spi_miso,
    input logic                  spi_miso_oe,
    input logic                  wr_stb,
    input logic                  cor_stb,
    input logic [NRW*DATA_W-1:0] rw_out
);
    AST_MISO_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_miso_oe |-> !spi_miso); // R5
    AST_NO_COMMIT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_miso_oe |-> !(wr_stb || cor_stb)); // R4
    AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb || cor_stb) |=> !(wr_stb || cor_stb)); // R10
    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && cor_stb)); // R1
    AST_RW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(rw_out)); // R2
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rw_out & ~{NRW{USED_MASK}}) == '0); // R6
endmodule

bind spi_reg_slave spi_reg_slave_chk #(
    .NRW       (NRW),
    .USED_MASK (USED_MASK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe),
    .wr_stb      (wr_stb),
    .cor_stb     (cor_stb),
    .rw_out      (rw_out)
);

// File: tb/sim_spi_reg_slave.sv
`timescale 1ns/1ps
// Self-checking bench for spi_reg_slave with a behavioural register model.
module sim_spi_reg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int TIMEOUT    = 100000;
    localparam int NRW = 8, NRO = 2, NW1C = 2, NCOR = 2, DW = 24;
    localparam logic [23:0] MASK = 24'hFFF0FF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_cs = 1'b0, spi_sck = 1'b0, spi_mosi = 1'b0;
    logic spi_miso, spi_miso_oe;
    logic [NRO*DW-1:0]  ro_status = '0;
    logic [NW1C*DW-1:0] evt_w1c = '0;
    logic [NCOR*DW-1:0] evt_cor = '0;
    logic [NRW*DW-1:0]  rw_out;

    int checks = 0;
    int errors = 0;
    int cs_low_cnt = 0;

    logic [23:0] m_rw  [NRW];
    logic [23:0] m_w1c [NW1C];
    logic [23:0] m_cor [NCOR];
    int inj_i = -1;
    int inj_slot = 0;
    logic [23:0] inj_v = '0;
    int extra_clks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_reg_slave u0 (
        .clk(clk), .rst_n(rst_n), .spi_cs(spi_cs), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .ro_status(ro_status), .evt_w1c(evt_w1c), .evt_cor(evt_cor), .rw_out(rw_out)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference read value of an address according to the requirements.
    function automatic logic [23:0] model_rd(input int a);
        if (a < 8)  return m_rw[a];
        if (a < 10) return ro_status[(a-8)*DW +: DW] & MASK;
        if (a < 12) return m_w1c[a-10];
        if (a < 14) return m_cor[a-12];
        return 24'h0;
    endfunction

    // Per-clock monitor: deselected line must be quiet and not enabled (R5).
    always @(posedge clk) cs_low_cnt <= spi_cs ? 0 : cs_low_cnt + 1;
    always @(negedge clk) begin
        if (rst_n && cs_low_cnt >= 4) begin
            checks++;
            if (spi_miso_oe !== 1'b0 || spi_miso !== 1'b0) begin
                errors++;
                $display("FAIL R5 deselected miso/oe: actual %b%b expected 00", spi_miso, spi_miso_oe);
            end
        end
    end

    task automatic check_rw_all(input string req);
        for (int i = 0; i < NRW; i++) chk(req, "rw_out", rw_out[i*DW +: DW], m_rw[i]);
    endtask

    // One host frame; abort_at = bit index at which CS drops (32 = between last rise and fall).
    task automatic frame(input bit dir, input int a, input logic [23:0] d,
                         input int abort_at, input string req);
        logic [31:0] f;
        logic [23:0] rv;
        logic        e;
        f  = {dir, 6'(a), 1'b0, d};
        rv = model_rd(a);
        spi_cs = 1'b1;
        wait_clk(HALF);
        for (int i = 0; i < 32; i++) begin
            if (abort_at == i) begin
                spi_cs = 1'b0;
                wait_clk(8);
                return;
            end
            if (inj_i == i) begin
                evt_cor[inj_slot*DW +: DW] = inj_v;
                wait_clk(1);
                evt_cor = '0;
                m_cor[inj_slot] = m_cor[inj_slot] | (inj_v & MASK);
            end
            spi_mosi = f[31-i];
            wait_clk(HALF);
            e = (i >= 8) ? rv[31-i] : 1'b0;
            chk(req, $sformatf("miso bit %0d", i), {23'h0, spi_miso}, {23'h0, e});
            spi_sck = 1'b1;
            wait_clk(HALF);
            if (abort_at == 32 && i == 31) begin
                spi_cs = 1'b0;
                wait_clk(HALF);
                spi_sck = 1'b0;
                wait_clk(8);
                return;
            end
            spi_sck = 1'b0;
        end
        for (int k = 0; k < extra_clks; k++) begin
            spi_mosi = 1'b1;
            wait_clk(HALF);
            chk("R10", "miso after frame", {23'h0, spi_miso}, 24'h0);
            spi_sck = 1'b1;
            wait_clk(HALF);
            spi_sck = 1'b0;
        end
        wait_clk(HALF);
        spi_cs = 1'b0;
        wait_clk(8);
        if (dir) begin
            if (a < 8) m_rw[a] = d & MASK;
            else if (a >= 10 && a < 12) m_w1c[a-10] = m_w1c[a-10] & ~d;
        end else if (a >= 12 && a < 14) begin
            m_cor[a-12] = m_cor[a-12] & ~rv;
        end
    endtask

    initial begin
        repeat (TIMEOUT) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NRW; i++)  m_rw[i]  = '0;
        for (int i = 0; i < NW1C; i++) m_w1c[i] = '0;
        for (int i = 0; i < NCOR; i++) m_cor[i] = '0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // Reset state
        chk("R5", "oe after reset", {23'h0, spi_miso_oe}, 24'h0);
        check_rw_all("R1");

        // R1 write, R6 masking, R3 readback
        frame(1'b1, 3, 24'hA5C3F1, -1, "R3");
        check_rw_all("R1");
        frame(1'b0, 3, 24'h000000, -1, "R3");
        // R2 read with all-ones data changes nothing
        frame(1'b0, 3, 24'hFFFFFF, -1, "R2");
        check_rw_all("R2");
        // R3 old value returned during a write
        frame(1'b1, 5, 24'h13579B, -1, "R3");
        frame(1'b1, 5, 24'h2468AC, -1, "R3");
        check_rw_all("R1");
        // R4 aborted writes
        frame(1'b1, 3, 24'h111111, 20, "R4");
        check_rw_all("R4");
        frame(1'b1, 3, 24'h222222, 32, "R4");
        check_rw_all("R4");
        frame(1'b0, 3, 24'h0, -1, "R4");
        // R6 unused bits and addresses
        frame(1'b1, 1, 24'hFFFFFF, -1, "R6");
        check_rw_all("R6");
        frame(1'b1, 40, 24'hFFFFFF, -1, "R6");
        frame(1'b0, 40, 24'h0, -1, "R6");
        check_rw_all("R6");
        // R7 read-only status
        ro_status[0 +: DW]  = 24'h123456;
        ro_status[DW +: DW] = 24'hFEDCBA;
        frame(1'b0, 8, 24'h0, -1, "R7");
        frame(1'b1, 9, 24'h000000, -1, "R7");
        frame(1'b0, 9, 24'h0, -1, "R7");
        check_rw_all("R7");
        // R8 write-one-to-clear flags
        evt_w1c[0 +: DW] = 24'h00F00F;
        wait_clk(1);
        evt_w1c = '0;
        m_w1c[0] = 24'h00F00F & MASK;
        wait_clk(2);
        frame(1'b0, 10, 24'h0, -1, "R8");
        frame(1'b1, 10, 24'h00300A, -1, "R8");
        frame(1'b0, 10, 24'h0, -1, "R8");
        frame(1'b1, 10, 24'h000000, -1, "R8");
        frame(1'b0, 10, 24'h0, -1, "R8");
        // R9 clear-on-read with an event after capture
        evt_cor[DW +: DW] = 24'h0000F0;
        wait_clk(1);
        evt_cor = '0;
        m_cor[1] = 24'h0000F0;
        wait_clk(2);
        inj_i = 16; inj_slot = 1; inj_v = 24'h010000;
        frame(1'b0, 13, 24'h0, -1, "R9");
        inj_i = -1;
        frame(1'b0, 13, 24'h0, -1, "R9");
        frame(1'b0, 13, 24'h0, -1, "R9");
        // R10 extra clocks after the frame
        extra_clks = 8;
        frame(1'b1, 2, 24'h00ABCD, -1, "R10");
        extra_clks = 0;
        check_rw_all("R10");
        frame(1'b0, 2, 24'h0, -1, "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule